// File: doc/BRIEF.md
# Capability permission mask legalizer

This block narrows the access rights of a capability. The permission fields of the source capability are ANDed with a software-supplied mask word. The block then repairs the narrowed set with a fixed, ordered chain of dependency rules, so that what leaves it is a legal, minimal permission set. The rights handled are read (R), write (W), capability load/store (C), load-mutable (LM), elevate-level (EL), execute (X), access-system-registers (ASR), a store level SL of `LVLBITS` bits, and a mode bit M.

The rules come in two strengths. A common set applies in both widths. A stricter set applies only when `rv32_mode` is high, because the 32-bit permission encoding can hold fewer combinations. A source whose permissions could not have come out of this operation is not narrowed: it is flattened to an empty set. The output tag drops when the source is sealed or has a reserved field set.

One operation is accepted per cycle on `valid_in`. The result appears on the registered outputs, flagged by `valid_out`.

Top module: `cap_perm_legalizer`

## Requirements
- R1: Mask bit positions are R=0, W=1, C=2, LM=3, EL=4, X=5, ASR=6, SL bits at 7 up to 6+LVLBITS, and M at 7+LVLBITS. Each output field is at most the source field ANDed with its mask bit. Mask bits above 7+LVLBITS have no effect.
- R2: A source counts as producible only when applying the rules for the selected width leaves it unchanged. For any other source, every output permission is clear, SL is 0 and M is 0 (capability mode), whatever the mask.
- R3: out_tag is 0 when in_sealed or in_rsvd is set. Otherwise it equals in_tag.
- R4: C survives only if R or W survives, in both widths.
- R5: EL and LM each survive only if both C and R survive, in both widths.
- R6: SL becomes 0 (local) unless C survives, in both widths.
- R7: ASR survives only if X survives, and M survives only if X survives. X=0 together with M=1 never appears on the outputs.
- R8: With rv32_mode=1, ASR survives only if R, W, C, LM, EL and X are all set and SL is all ones. With rv32_mode=0 this rule is absent.
- R9: With rv32_mode=1, C and X each survive only if R survives.
- R10: With rv32_mode=1, W survives only if C is clear or LM is set, and X survives only if W or C is set.
- R11: With rv32_mode=1, X survives only if either (C, LM and EL are all set and SL is all ones) or (C, LM and EL are all clear and SL is 0).
- R12: The rules run once, in the order R8 ASR, R4 C, R9 C, R9 X, R10 W, R10 X, R5 EL, R5 LM, R6 SL, R11 X, R7 ASR, R7 M. Each rule sees the values left by the rules before it.
- R13: Outputs and valid_out update one clock after a cycle with valid_in=1. While valid_in=0, valid_out is 0 and the data outputs hold their values. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation request |
| rv32_mode | input | 1 | 1 selects the stricter 32-bit rule set |
| mask | input | MASK_W | Permission mask word |
| in_r | input | 1 | Source read permission |
| in_w | input | 1 | Source write permission |
| in_c | input | 1 | Source capability load/store permission |
| in_lm | input | 1 | Source load-mutable permission |
| in_el | input | 1 | Source elevate-level permission |
| in_x | input | 1 | Source execute permission |
| in_asr | input | 1 | Source system-register access permission |
| in_sl | input | LVLBITS | Source store level |
| in_m | input | 1 | Source mode bit (0 = capability mode) |
| in_sealed | input | 1 | Source is sealed |
| in_rsvd | input | 1 | Source has a reserved field set |
| in_tag | input | 1 | Source tag |
| valid_out | output | 1 | Result valid |
| out_r | output | 1 | Result read permission |
| out_w | output | 1 | Result write permission |
| out_c | output | 1 | Result capability load/store permission |
| out_lm | output | 1 | Result load-mutable permission |
| out_el | output | 1 | Result elevate-level permission |
| out_x | output | 1 | Result execute permission |
| out_asr | output | 1 | Result system-register access permission |
| out_sl | output | LVLBITS | Result store level |
| out_m | output | 1 | Result mode bit |
| out_tag | output | 1 | Result tag |

## Verification
All results, including out_tag, are due on the first rising edge after the edge that samples valid_in=1. Nothing is combinational to the outputs. The bench drives each request on a falling edge and reads every output on the next falling edge. That point lies past the one capturing edge and before the following one, so the read sees the registered result and nothing else. The hold scenario changes the inputs with valid_in low over two edges and then expects both unchanged data and valid_out low. The random scenario checks the same one-edge timing against legality predicates and the masked-subset bound.

// File: rtl/cap_perm_legalizer.sv
`timescale 1ns/1ps
module cap_perm_legalizer #(
  parameter int LVLBITS = 1,
  parameter int MASK_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_in,
  input  logic               rv32_mode,
  input  logic [MASK_W-1:0]  mask,
  input  logic               in_r,
  input  logic               in_w,
  input  logic               in_c,
  input  logic               in_lm,
  input  logic               in_el,
  input  logic               in_x,
  input  logic               in_asr,
  input  logic [LVLBITS-1:0] in_sl,
  input  logic               in_m,
  input  logic               in_sealed,
  input  logic               in_rsvd,
  input  logic               in_tag,
  output logic               valid_out,
  output logic               out_r,
  output logic               out_w,
  output logic               out_c,
  output logic               out_lm,
  output logic               out_el,
  output logic               out_x,
  output logic               out_asr,
  output logic [LVLBITS-1:0] out_sl,
  output logic               out_m,
  output logic               out_tag
);
  localparam int PW = 8 + LVLBITS;

  function automatic logic [PW-1:0] apply_rules(input logic [PW-1:0] p, input logic narrow);
    logic r, w, c, lm, el, x, asr, m;
    logic [LVLBITS-1:0] sl;
    {m, sl, asr, x, el, lm, c, w, r} = p;
    if (narrow && !(r && w && c && lm && el && x && (&sl))) asr = 1'b0;
    if (!(r || w))                  c  = 1'b0;
    if (narrow && !r)               c  = 1'b0;
    if (narrow && !r)               x  = 1'b0;
    if (narrow && c && !lm)         w  = 1'b0;
    if (narrow && !(w || c))        x  = 1'b0;
    if (!(c && r))                  el = 1'b0;
    if (!(c && r))                  lm = 1'b0;
    if (!c)                         sl = '0;
    if (narrow && !((c && lm && el && (&sl)) || (!c && !lm && !el && (sl == '0))))
                                    x  = 1'b0;
    if (!x)                         asr = 1'b0;
    if (!x)                         m   = 1'b0;
    return {m, sl, asr, x, el, lm, c, w, r};
  endfunction

  logic [PW-1:0] src, masked, result, res_q;
  logic          producible, tag_q;
  logic          unused_mask_hi;

  assign src            = {in_m, in_sl, in_asr, in_x, in_el, in_lm, in_c, in_w, in_r};
  assign masked         = src & mask[PW-1:0];
  assign unused_mask_hi = ^mask[MASK_W-1:PW];
  assign producible     = (apply_rules(src, rv32_mode) == src);
  assign result         = producible ? apply_rules(masked, rv32_mode) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      res_q     <= '0;
      tag_q     <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        res_q <= result;
        tag_q <= in_tag && !in_sealed && !in_rsvd;
      end
    end
  end

  assign {out_m, out_sl, out_asr, out_x, out_el, out_lm, out_c, out_w, out_r} = res_q;
  assign out_tag = tag_q;

  a_r1_read_subset: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (!out_r || $past(in_r && mask[0])));
  a_r2_reserved_src_flat: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && in_m && !in_x |=> (res_q == '0));
  a_r3_tag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && (in_sealed || in_rsvd) |=> !out_tag);
  a_r4_cap_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && out_c |-> (out_r || out_w));
  a_r5_el_lm_need_cr: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && (out_el || out_lm) |-> (out_c && out_r));
  a_r6_sl_needs_c: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && (out_sl != '0) |-> out_c);
  a_r7_x_gates_asr_m: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (out_x || (!out_asr && !out_m)));
  a_r8_asr_all_set: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && rv32_mode |=> (!out_asr || (out_r && out_w && out_c && out_lm && out_el && out_x && (&out_sl))));
  a_r9_c_x_need_r: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && rv32_mode |=> (out_r || (!out_c && !out_x)));
  a_r10_w_and_x: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && rv32_mode |=> ((!out_w || !out_c || out_lm) && (!out_x || out_w || out_c)));
  a_r11_x_extremes: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && rv32_mode |=> (!out_x || (out_c && out_lm && out_el && (&out_sl)) ||
                                         (!out_c && !out_lm && !out_el && (out_sl == '0))));
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(res_q) && $stable(out_tag)));
endmodule

// File: tb/tb_cap_perm_legalizer.sv
`timescale 1ns/1ps
module tb_cap_perm_legalizer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_in = 1'b0, rv32 = 1'b0, sealed = 1'b0, rsvd = 1'b0, tag = 1'b0;
  logic [31:0] mask = '0;
  logic [8:0]  iv = '0;
  logic [8:0]  ov;
  logic        valid_out, out_tag;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_perm_legalizer dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .rv32_mode(rv32), .mask(mask),
    .in_r(iv[0]), .in_w(iv[1]), .in_c(iv[2]), .in_lm(iv[3]), .in_el(iv[4]),
    .in_x(iv[5]), .in_asr(iv[6]), .in_sl(iv[7]), .in_m(iv[8]),
    .in_sealed(sealed), .in_rsvd(rsvd), .in_tag(tag),
    .valid_out(valid_out),
    .out_r(ov[0]), .out_w(ov[1]), .out_c(ov[2]), .out_lm(ov[3]), .out_el(ov[4]),
    .out_x(ov[5]), .out_asr(ov[6]), .out_sl(ov[7]), .out_m(ov[8]), .out_tag(out_tag));

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic run_op(input logic [8:0] src, input logic [31:0] m, input logic narrow);
    @(negedge clk);
    iv = src; mask = m; rv32 = narrow; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic op_check(input string what, input logic [8:0] src, input logic [31:0] m,
                          input logic narrow, input logic [8:0] exp);
    run_op(src, m, narrow);
    check({what, " valid"}, {31'b0, valid_out}, 32'd1);
    check(what, {23'b0, ov}, {23'b0, exp});
  endtask

  task automatic t_reset;
    check("R13 reset perms", {23'b0, ov}, 32'd0);
    check("R13 reset valid/tag", {30'b0, valid_out, out_tag}, 32'd0);
  endtask

  task automatic t_common;
    op_check("R1 full rv64 passes", 9'h1FF, 32'h1FF, 1'b0, 9'h1FF);
    op_check("R4 R5 R6 drop R rv64", 9'h1FF, 32'h1FE, 1'b0, 9'h1E6);
    op_check("R4 R6 drop R,W rv64", 9'h1FF, 32'h1FC, 1'b0, 9'h160);
    op_check("R7 drop X rv64", 9'h1FF, 32'h1DF, 1'b0, 9'h09F);
    op_check("R5 R6 drop C rv64", 9'h1FF, 32'h1FB, 1'b0, 9'h163);
  endtask

  task automatic t_narrow;
    op_check("R9 drop R rv32", 9'h0FF, 32'h1FE, 1'b1, 9'h002);
    op_check("R11 R12 drop EL rv32", 9'h1FF, 32'h1EF, 1'b1, 9'h08F);
    op_check("R10 drop LM rv32", 9'h0FF, 32'h1F7, 1'b1, 9'h095);
    op_check("R10 X needs W|C rv32", 9'h023, 32'h1FD, 1'b1, 9'h001);
    op_check("R8 R11 SL cleared rv32", 9'h0FF, 32'h17F, 1'b1, 9'h01F);
    op_check("R8 SL cleared rv64 keeps ASR", 9'h0FF, 32'h17F, 1'b0, 9'h07F);
  endtask

  task automatic t_flatten;
    op_check("R2 X0 M1 source", 9'h100, 32'h1FF, 1'b0, 9'h000);
    op_check("R2 lone C source", 9'h004, 32'h1FF, 1'b0, 9'h000);
    op_check("R2 producible rv64", 9'h17F, 32'h1FF, 1'b0, 9'h17F);
    op_check("R2 same source rv32", 9'h17F, 32'h1FF, 1'b1, 9'h000);
  endtask

  task automatic t_mask_bits;
    op_check("R1 high mask bits ignored", 9'h0FF, 32'hFFFF_FFFF, 1'b1, 9'h0FF);
    op_check("R1 only high mask bits", 9'h0FF, 32'hFFFF_FE00, 1'b1, 9'h000);
    op_check("R1 mask clears M", 9'h1FF, 32'h0FF, 1'b0, 9'h0FF);
  endtask

  task automatic t_tag;
    tag = 1'b1; sealed = 1'b0; rsvd = 1'b0;
    run_op(9'h003, 32'h1FF, 1'b0);
    check("R3 tag passes", {31'b0, out_tag}, 32'd1);
    sealed = 1'b1;
    run_op(9'h003, 32'h1FF, 1'b0);
    check("R3 sealed drops tag", {31'b0, out_tag}, 32'd0);
    sealed = 1'b0; rsvd = 1'b1;
    run_op(9'h003, 32'h1FF, 1'b0);
    check("R3 reserved drops tag", {31'b0, out_tag}, 32'd0);
    rsvd = 1'b0; tag = 1'b0;
    run_op(9'h003, 32'h1FF, 1'b0);
    check("R3 clear tag stays clear", {31'b0, out_tag}, 32'd0);
  endtask

  task automatic t_hold;
    tag = 1'b1;
    op_check("R13 load value", 9'h1FF, 32'h1FF, 1'b0, 9'h1FF);
    @(negedge clk);
    iv = 9'h000; mask = '0; rv32 = 1'b1; tag = 1'b0; sealed = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R13 hold data", {23'b0, ov}, 32'h1FF);
    check("R13 hold valid/tag", {30'b0, valid_out, out_tag}, 32'd1);
    sealed = 1'b0;
  endtask

  function automatic bit legal(input logic [8:0] o, input logic narrow);
    bit ok;
    ok = !(o[2] && !(o[0] || o[1]));
    ok &= !((o[4] || o[3]) && !(o[2] && o[0]));
    ok &= !(o[7] && !o[2]);
    ok &= !((o[6] || o[8]) && !o[5]);
    if (narrow) begin
      ok &= !(o[6] && (o[5:0] != 6'h3F || !o[7]));
      ok &= !((o[2] || o[5]) && !o[0]);
      ok &= !(o[1] && o[2] && !o[3]);
      ok &= !(o[5] && !(o[1] || o[2]));
      ok &= !(o[5] && !((o[2] && o[3] && o[4] && o[7]) || (!o[2] && !o[3] && !o[4] && !o[7])));
    end
    return ok;
  endfunction

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [8:0]  s;
      logic [31:0] m;
      logic        n;
      s = 9'($urandom); m = $urandom; n = 1'($urandom);
      run_op(s, m, n);
      checks++;
      if (!valid_out || !legal(ov, n) || ((ov & ~(s & m[8:0])) != 9'h0)) begin
        errors++;
        $display("FAIL random R1 R4 R5 R6 R7 R8 R9 R10 R11: src %h mask %h rv32 %0d got %h", s, m, n, ov);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_common();
    t_narrow();
    t_flatten();
    t_mask_bits();
    t_tag();
    t_hold();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule